// File: doc/BRIEF.md
# Tuner Synthesizer Programming Slave (I2C Write Path)

This block is the write-only two-wire bus front end of a frequency synthesizer's control registers. It samples the clock and data lines in the system clock domain and detects START and STOP. When the address byte carries the slave's own 7-bit address with the write flag, it acknowledges that byte and every data byte that follows. Five fixed address bits come from a parameter. The two lowest address bits come from a strap input, so four such slaves can share one bus.

Data bytes go into a five-entry register sequence through a pointer that advances by one after each byte. No sub-address byte is sent. The top bit of the first data byte picks the entry where loading starts: the divider pair or the first control byte. Control bytes reach their outputs as soon as their eighth bit is clocked in. The two divider bytes are only staged during the transfer. They move to the divider outputs once the transfer ends with STOP and a settling window has then run out. A START inside that window discards the staged divider.

The 3-bit ratio field of the first control byte is handled like the divider. A new ratio value is applied only together with a divider commit.

Top module: `tuner_i2c_regs`

## Requirements
- R1: The slave acknowledges an address byte only when it equals {ADDR_HI, addr_sel, 0}, with the R/W bit in bit 0 and the default ADDR_HI = 5'b11000. Acknowledge means holding the data line low for the ninth clock. A byte with any other value is not acknowledged and changes no output.
- R2: A byte that carries the slave's own address with R/W = 1 is not acknowledged. The transfer that follows changes no output.
- R3: The first data byte after the address sets the starting register. Bit 7 = 0 starts at divider byte 1, and bit 7 = 1 starts at control byte 1.
- R4: Each further data byte goes to the next register, in this order: divider byte 1 (div_hi), divider byte 2 (div_lo), control byte 1 (ctrl1), auxiliary byte 1 (aux1), auxiliary byte 2 (aux2).
- R5: Every data byte of an addressed write is acknowledged. Bytes after aux2 are ignored and change no output.
- R6: ctrl1[7:3], aux1 and aux2 take a written byte right after its eighth clock rising edge, before the transfer ends.
- R7: div_hi and div_lo change only when all of these hold: the transfer has ended with STOP, and SETTLE_US microseconds of system clock (CLK_HZ) have then passed without a START.
- R8: A START inside that settling window discards the pending divider, and the divider outputs keep their old values.
- R9: A transfer that wrote only one of the two divider bytes leaves div_hi and div_lo unchanged.
- R10: The ratio field ctrl1[2:0] takes a written value only at a divider commit. The control byte must have been written in the same transfer as both divider bytes. Otherwise the field keeps its previous value.
- R11: After reset all register outputs are zero and the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as sampled from the pad |
| sda_i | input | 1 | Bus data line as sampled from the pad |
| addr_sel | input | 2 | Strap value for the two lowest address bits |
| sda_drive_low | output | 1 | High while the slave pulls the data line low (acknowledge) |
| div_hi | output | 8 | Committed divider byte 1 |
| div_lo | output | 8 | Committed divider byte 2 |
| ctrl1 | output | 8 | Control byte 1; bits 2:0 are the committed ratio field |
| aux1 | output | 8 | Auxiliary control byte 1 |
| aux2 | output | 8 | Auxiliary control byte 2 |

## Verification
The hardest case to reach is a START that arrives inside the settling window. It has to come after a STOP that did leave a divider pair pending, but before the window counter runs out. The stimulus sends a complete divider transfer, waits a fixed hundred cycles (well below the five-hundred-cycle window), then begins a control-only transfer. Both divider outputs must keep their old values. Random transfers of one to seven data bytes, with random starting bits, wrong addresses and read requests, cover saturation of the pointer and partial divider writes.

// File: rtl/tpr_pkg.sv
package tpr_pkg;
    localparam int BYTE_W   = 8;
    localparam int BIT_W    = $clog2(BYTE_W);
    localparam int ADDR_W   = 7;
    localparam int SEL_W    = 2;
    localparam int RATIO_W  = 3;
    localparam int NUM_REGS = 5;
    localparam int PTR_W    = $clog2(NUM_REGS + 1);

    // register sequence order (the pointer walks it)
    localparam logic [PTR_W-1:0] IDX_DIV1 = PTR_W'(0);
    localparam logic [PTR_W-1:0] IDX_DIV2 = PTR_W'(1);
    localparam logic [PTR_W-1:0] IDX_CTRL = PTR_W'(2);
    localparam logic [PTR_W-1:0] IDX_AUX1 = PTR_W'(3);
    localparam logic [PTR_W-1:0] IDX_AUX2 = PTR_W'(4);
    localparam logic [PTR_W-1:0] IDX_SAT  = PTR_W'(NUM_REGS);

    typedef enum logic [2:0] {
        BS_IDLE,
        BS_ADDR,
        BS_ADDR_ACK,
        BS_DATA,
        BS_DATA_ACK,
        BS_SKIP
    } bus_state_e;

    typedef enum logic {
        CM_IDLE,
        CM_SETTLE
    } commit_state_e;
endpackage

// File: rtl/tpr_bus_sync.sv
module tpr_bus_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_meta, sda_meta, scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_meta <= 1'b1;
            sda_meta <= 1'b1;
            scl_s    <= 1'b1;
            sda_s    <= 1'b1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_meta <= scl_i;
            sda_meta <= sda_i;
            scl_s    <= scl_meta;
            sda_s    <= sda_meta;
            scl_d    <= scl_s;
            sda_d    <= sda_s;
        end
    end

    always_comb begin
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/tpr_byte_fsm.sv
module tpr_byte_fsm
    import tpr_pkg::*;
#(
    parameter logic [ADDR_W-SEL_W-1:0] ADDR_HI = 5'b11000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [SEL_W-1:0]  addr_sel,
    output logic              ack_drive,
    output logic              byte_stb,
    output logic [BYTE_W-1:0] byte_q,
    output logic              xfer_begin,
    output logic              xfer_end,
    output logic              bus_idle
);
    bus_state_e        state_q, state_nx;
    logic [BIT_W-1:0]  bit_cnt;
    logic              full_q;
    logic              match_q;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] shifted;
    logic [BYTE_W-1:0] own_write;
    logic              in_shift;
    logic              last_bit;

    assign shifted   = {shreg[BYTE_W-2:0], sda_s};
    assign own_write = {ADDR_HI, addr_sel, 1'b0};
    assign in_shift  = (state_q == BS_ADDR) || (state_q == BS_DATA);
    assign last_bit  = in_shift && scl_rise && !full_q
                       && (bit_cnt == BIT_W'(BYTE_W - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BS_IDLE;
        else        state_q <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state_q;
        if (start_det) begin
            state_nx = BS_ADDR;
        end else if (stop_det) begin
            state_nx = BS_IDLE;
        end else begin
            unique case (state_q)
                BS_IDLE:     state_nx = BS_IDLE;
                BS_ADDR:     if (scl_fall && full_q)
                                 state_nx = match_q ? BS_ADDR_ACK : BS_SKIP;
                BS_ADDR_ACK: if (scl_fall) state_nx = BS_DATA;
                BS_DATA:     if (scl_fall && full_q) state_nx = BS_DATA_ACK;
                BS_DATA_ACK: if (scl_fall) state_nx = BS_DATA;
                BS_SKIP:     state_nx = BS_SKIP;
                default:     state_nx = BS_IDLE;
            endcase
        end
    end

    // bit shifter and byte strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            full_q   <= 1'b0;
            match_q  <= 1'b0;
            shreg    <= '0;
            byte_stb <= 1'b0;
            byte_q   <= '0;
        end else begin
            byte_stb <= 1'b0;
            if (start_det) begin
                bit_cnt <= '0;
                full_q  <= 1'b0;
            end else if (in_shift) begin
                if (scl_rise && !full_q) begin
                    shreg   <= shifted;
                    bit_cnt <= bit_cnt + BIT_W'(1);
                    if (last_bit) full_q <= 1'b1;
                end else if (scl_fall && full_q) begin
                    full_q  <= 1'b0;
                    bit_cnt <= '0;
                end
                if (last_bit && state_q == BS_ADDR)
                    match_q <= (shifted == own_write);
                if (last_bit && state_q == BS_DATA) begin
                    byte_stb <= 1'b1;
                    byte_q   <= shifted;
                end
            end
        end
    end

    // outputs
    always_comb begin
        ack_drive  = (state_q == BS_ADDR_ACK) || (state_q == BS_DATA_ACK);
        xfer_begin = (state_q == BS_ADDR) && scl_fall && full_q && match_q
                     && !start_det && !stop_det;
        xfer_end   = stop_det && ((state_q == BS_ADDR_ACK)
                     || (state_q == BS_DATA) || (state_q == BS_DATA_ACK));
        bus_idle   = (state_q == BS_IDLE);
    end
endmodule

// File: rtl/tpr_regfile.sv
module tpr_regfile
    import tpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_begin,
    input  logic              byte_stb,
    input  logic [BYTE_W-1:0] byte_q,
    input  logic              commit,
    output logic              div_pair,
    output logic [BYTE_W-1:0] div_hi,
    output logic [BYTE_W-1:0] div_lo,
    output logic [BYTE_W-1:0] ctrl1,
    output logic [BYTE_W-1:0] aux1,
    output logic [BYTE_W-1:0] aux2
);
    logic [PTR_W-1:0]          ptr_q;
    logic [PTR_W-1:0]          wr_idx;
    logic                      wr_en;
    logic                      first_q;
    logic                      got_div1, got_div2, got_ctrl;
    logic [BYTE_W-1:0]         stg_div1, stg_div2;
    logic [RATIO_W-1:0]        stg_ratio, ratio_q;
    logic [BYTE_W-1:RATIO_W]   ctrl_hi_q;

    always_comb begin
        if (first_q) wr_idx = byte_q[BYTE_W-1] ? IDX_CTRL : IDX_DIV1;
        else         wr_idx = ptr_q;
        wr_en = byte_stb && (wr_idx < IDX_SAT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q     <= IDX_DIV1;
            first_q   <= 1'b0;
            got_div1  <= 1'b0;
            got_div2  <= 1'b0;
            got_ctrl  <= 1'b0;
            stg_div1  <= '0;
            stg_div2  <= '0;
            stg_ratio <= '0;
            ratio_q   <= '0;
            ctrl_hi_q <= '0;
            aux1      <= '0;
            aux2      <= '0;
            div_hi    <= '0;
            div_lo    <= '0;
        end else begin
            if (xfer_begin) begin
                ptr_q    <= IDX_DIV1;
                first_q  <= 1'b1;
                got_div1 <= 1'b0;
                got_div2 <= 1'b0;
                got_ctrl <= 1'b0;
            end else if (byte_stb) begin
                first_q <= 1'b0;
                if (wr_en) begin
                    ptr_q <= wr_idx + PTR_W'(1);
                    unique case (wr_idx)
                        IDX_DIV1: begin stg_div1 <= byte_q; got_div1 <= 1'b1; end
                        IDX_DIV2: begin stg_div2 <= byte_q; got_div2 <= 1'b1; end
                        IDX_CTRL: begin
                            ctrl_hi_q <= byte_q[BYTE_W-1:RATIO_W];
                            stg_ratio <= byte_q[RATIO_W-1:0];
                            got_ctrl  <= 1'b1;
                        end
                        IDX_AUX1: aux1 <= byte_q;
                        IDX_AUX2: aux2 <= byte_q;
                        default:  ;
                    endcase
                end
            end
            if (commit) begin
                div_hi <= stg_div1;
                div_lo <= stg_div2;
                if (got_ctrl) ratio_q <= stg_ratio;
            end
        end
    end

    assign div_pair = got_div1 & got_div2;
    assign ctrl1    = {ctrl_hi_q, ratio_q};
endmodule

// File: rtl/tpr_commit.sv
module tpr_commit
    import tpr_pkg::*;
#(
    parameter int SETTLE_CYC = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_end,
    input  logic div_pair,
    input  logic bus_start,
    output logic commit
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

    commit_state_e   state_q, state_nx;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CM_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            CM_IDLE:   if (xfer_end && div_pair) state_nx = CM_SETTLE;
            CM_SETTLE: if (bus_start || cnt_q == LAST) state_nx = CM_IDLE;
            default:   state_nx = CM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (state_q == CM_IDLE) cnt_q <= '0;
        else                         cnt_q <= cnt_q + CNT_W'(1);
    end

    always_comb begin
        commit = (state_q == CM_SETTLE) && !bus_start && (cnt_q == LAST);
    end
endmodule

// File: rtl/tuner_i2c_regs.sv
module tuner_i2c_regs
    import tpr_pkg::*;
#(
    parameter int                      CLK_HZ    = 10_000_000,
    parameter int                      SETTLE_US = 50,
    parameter logic [ADDR_W-SEL_W-1:0] ADDR_HI   = 5'b11000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [SEL_W-1:0]  addr_sel,
    output logic              sda_drive_low,
    output logic [BYTE_W-1:0] div_hi,
    output logic [BYTE_W-1:0] div_lo,
    output logic [BYTE_W-1:0] ctrl1,
    output logic [BYTE_W-1:0] aux1,
    output logic [BYTE_W-1:0] aux2
);
    localparam int SETTLE_CYC = (CLK_HZ / 1_000_000) * SETTLE_US;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic byte_stb, xfer_begin, xfer_end, bus_idle, div_pair, commit;
    logic [BYTE_W-1:0] byte_q;

    tpr_bus_sync i_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    tpr_byte_fsm #(.ADDR_HI(ADDR_HI)) i_fsm (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .addr_sel(addr_sel), .ack_drive(sda_drive_low), .byte_stb(byte_stb),
        .byte_q(byte_q), .xfer_begin(xfer_begin), .xfer_end(xfer_end),
        .bus_idle(bus_idle)
    );

    tpr_regfile i_regs (
        .clk(clk), .rst_n(rst_n), .xfer_begin(xfer_begin), .byte_stb(byte_stb),
        .byte_q(byte_q), .commit(commit), .div_pair(div_pair),
        .div_hi(div_hi), .div_lo(div_lo), .ctrl1(ctrl1), .aux1(aux1), .aux2(aux2)
    );

    tpr_commit #(.SETTLE_CYC(SETTLE_CYC)) i_commit (
        .clk(clk), .rst_n(rst_n), .xfer_end(xfer_end), .div_pair(div_pair),
        .bus_start(start_det), .commit(commit)
    );
endmodule

// File: rtl/tpr_checker.sv
module tpr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       sda_drive_low,
    input logic       bus_idle,
    input logic       commit,
    input logic       byte_stb,
    input logic [7:0] div_hi,
    input logic [7:0] div_lo,
    input logic [7:0] ctrl1,
    input logic [7:0] aux1,
    input logic [7:0] aux2
);
    // R1: acknowledge is only ever started while the bus clock is low
    assert_ack_on_low_clock_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low) |-> !scl_s);

    // R8: a commit never lands while a newer transfer occupies the bus
    assert_commit_bus_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> bus_idle);

    // R7: divider outputs move only in the cycle after a commit
    assert_div_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({div_hi, div_lo}) |-> $past(commit));

    // R7: a commit is a single-cycle event
    assert_commit_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    // R10: ratio field follows the divider commit only
    assert_ratio_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl1[2:0]) |-> $past(commit));

    // R6: immediate control outputs change only right after a received byte
    assert_ctrl_on_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({ctrl1[7:3], aux1, aux2}) |-> $past(byte_stb));
endmodule

bind tuner_i2c_regs tpr_checker i_tpr_checker (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_drive_low(sda_drive_low),
    .bus_idle(bus_idle), .commit(commit), .byte_stb(byte_stb),
    .div_hi(div_hi), .div_lo(div_lo), .ctrl1(ctrl1), .aux1(aux1), .aux2(aux2)
);

// File: tb/test_tuner_i2c_regs.sv
module test_tuner_i2c_regs;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;     // quarter bus bit in system clocks
    localparam int SETTLE     = 500;    // 10 MHz * 50 us
    localparam logic [7:0] OWN_WR = 8'hC4;   // {11000, 10, 0}
    localparam logic [7:0] OWN_RD = 8'hC5;
    localparam logic [7:0] OTHER  = 8'hC0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [1:0] addr_sel = 2'b10;
    logic sda_drive_low;
    logic [7:0] div_hi, div_lo, ctrl1, aux1, aux2;
    logic sda_line;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_line = sda_m & ~sda_drive_low;

    tuner_i2c_regs i_tuner_i2c_regs (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .addr_sel(addr_sel), .sda_drive_low(sda_drive_low),
        .div_hi(div_hi), .div_lo(div_lo), .ctrl1(ctrl1), .aux1(aux1), .aux2(aux2)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] tx [8];
    // bench model
    logic [7:0] m_div1 = 0, m_div2 = 0, m_ctrl = 0, m_aux1 = 0, m_aux2 = 0;
    logic [2:0] m_ratio = 0;
    logic [7:0] p1, p2;
    logic [2:0] pr;
    bit g1, g2, gc, m_first;
    int m_ptr;

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_byte(input logic [7:0] b);
        int idx;
        idx = m_first ? (b[7] ? 2 : 0) : m_ptr;
        m_first = 1'b0;
        if (idx < 5) begin
            case (idx)
                0: begin p1 = b; g1 = 1'b1; end
                1: begin p2 = b; g2 = 1'b1; end
                2: begin m_ctrl = b; pr = b[2:0]; gc = 1'b1; end
                3: m_aux1 = b;
                default: m_aux2 = b;
            endcase
            m_ptr = idx + 1;
        end
    endtask

    task automatic model_commit();
        if (g1 && g2) begin
            m_div1 = p1;
            m_div2 = p2;
            if (gc) m_ratio = pr;
        end
    endtask

    task automatic check_imm(input string tag);
        chk8({tag, " R6 ctrl1[7:3]"}, ctrl1 & 8'hF8, m_ctrl & 8'hF8);
        chk8({tag, " R6 aux1"}, aux1, m_aux1);
        chk8({tag, " R6 aux2"}, aux2, m_aux2);
    endtask

    task automatic check_all(input string tag);
        check_imm(tag);
        chk8({tag, " div_hi"}, div_hi, m_div1);
        chk8({tag, " div_lo"}, div_lo, m_div2);
        chk8({tag, " ratio"}, {5'd0, ctrl1[2:0]}, {5'd0, m_ratio});
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b1; wait_clk(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_clk(Q);
            scl_m = 1'b1; wait_clk(2*Q);
            scl_m = 1'b0; wait_clk(Q);
        end
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        acked = !sda_line;
        wait_clk(Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    // address byte, then n data bytes from tx if acknowledged; no STOP
    task automatic xfer(input logic [7:0] ab, input int n, input bit exp_ack, input string tag);
        bit a;
        i2c_start();
        send_byte(ab, a);
        chk8({tag, " R1 address ack"}, {7'd0, a}, {7'd0, exp_ack});
        if (a) begin
            m_first = 1'b1; m_ptr = 0; g1 = 1'b0; g2 = 1'b0; gc = 1'b0;
            for (int i = 0; i < n; i++) begin
                send_byte(tx[i], a);
                chk8({tag, " R5 data ack"}, {7'd0, a}, 8'd1);
                model_byte(tx[i]);
                check_imm(tag);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        wait_clk(5);
        chk8("R11 reset div_hi", div_hi, 8'h00);
        chk8("R11 reset div_lo", div_lo, 8'h00);
        chk8("R11 reset ctrl1", ctrl1, 8'h00);
        chk8("R11 reset aux", aux1 | aux2, 8'h00);
        chk8("R11 reset sda", {7'd0, sda_drive_low}, 8'h00);
        rst_n = 1'b1;
        wait_clk(5);

        // R3 R4 R7 R10: full sequence from divider byte 1
        tx[0] = 8'h12; tx[1] = 8'h34; tx[2] = 8'hA5; tx[3] = 8'h5A; tx[4] = 8'h3C;
        xfer(OWN_WR, 5, 1'b1, "T2");
        i2c_stop();
        wait_clk(SETTLE - 50);
        chk8("T2 R7 div held during window", div_hi, 8'h00);
        chk8("T2 R10 ratio held during window", {5'd0, ctrl1[2:0]}, 8'h00);
        wait_clk(100);
        model_commit();
        check_all("T2 R3 R4 R7 R10");

        // R3 R5 R10: start at control byte, extra bytes ignored, ratio held
        tx[0] = 8'hC2; tx[1] = 8'h11; tx[2] = 8'h22; tx[3] = 8'h99; tx[4] = 8'h77;
        xfer(OWN_WR, 5, 1'b1, "T3");
        i2c_stop();
        wait_clk(SETTLE + 50);
        model_commit();
        check_all("T3 R3 R5 R10");

        // R1: other address ignored; then strap changed so it matches
        tx[0] = 8'h9F;
        xfer(OTHER, 1, 1'b0, "T4");
        i2c_stop();
        wait_clk(SETTLE + 50);
        check_all("T4 R1 unaddressed");
        addr_sel = 2'b00;
        xfer(OTHER, 1, 1'b1, "T4b");
        i2c_stop();
        wait_clk(SETTLE + 50);
        model_commit();
        check_all("T4b R1 strap");
        addr_sel = 2'b10;

        // R2: read request not acknowledged
        xfer(OWN_RD, 0, 1'b0, "T5 R2");
        i2c_stop();
        wait_clk(SETTLE + 50);
        check_all("T5 R2 read");

        // R9: only divider byte 1
        tx[0] = 8'h7E;
        xfer(OWN_WR, 1, 1'b1, "T6");
        i2c_stop();
        wait_clk(SETTLE + 50);
        model_commit();
        check_all("T6 R9 single divider byte");

        // R8: START inside the window cancels the pending divider
        tx[0] = 8'h55; tx[1] = 8'h66; tx[2] = 8'hB3;
        xfer(OWN_WR, 3, 1'b1, "T7a");
        i2c_stop();
        wait_clk(100);
        tx[0] = 8'hE8;
        xfer(OWN_WR, 1, 1'b1, "T7b");
        i2c_stop();
        wait_clk(SETTLE + 50);
        model_commit();
        check_all("T7 R8 cancel");

        // random transfers
        for (int it = 0; it < 20; it++) begin
            int kind, n;
            logic [7:0] ab;
            kind = $urandom % 8;
            n = 1 + ($urandom % 7);
            for (int i = 0; i < 8; i++) tx[i] = 8'($urandom);
            ab = (kind == 0) ? OTHER : (kind == 1) ? OWN_RD : OWN_WR;
            xfer(ab, n, kind >= 2, "RND R4");
            i2c_stop();
            wait_clk(SETTLE + 50);
            if (kind >= 2) model_commit();
            check_all("RND R3 R4 R5 R9");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        wait_clk(190000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule